// File: doc/BRIEF.md
# Audio Converter Power-Up Initialization Sequencer

This block controls the digital output side of a two-channel audio converter around an active-low power-down pin. While power-down is held low, it holds the decimation filter in reset and forces both channel words to two's-complement zero. Once power-down is released, the pin is synchronized to the master clock. The block then waits for the first qualifying frame-clock edge. That edge arms a frame counter, and the counter then counts a fixed number of further frame periods. The outputs stay zero for the whole count.

When the count completes, a ready flag rises and the left and right sample words pass through unchanged. The flag and the pass-through start on the same frame edge, so no partial frame is ever released. A mode pin selects which frame-clock polarity counts: rising edges in one mode, falling edges in the other.

The sample stream uses a valid/ready handshake with no storage. Back-pressure is passed straight through: `s_ready` follows `m_ready`, and `m_valid` follows `s_valid`. Words that are forced to zero still travel as valid beats, so the serial path keeps its frame rhythm.

Top module: `adc_init_seq`

## Requirements
- R1: While `pwr_dn_n` is low, `filt_rst` is 1, `conv_ready` is 0 and both output words are 0. This takes effect without waiting for a master-clock edge.
- R2: Whenever `conv_ready` is 0, `m_left` and `m_right` are 0, whatever the input words are.
- R3: After release, the first qualifying frame-clock edge arms the counter. `conv_ready` rises on the INIT_FRAMES-th qualifying edge after that one (default 4129) and not on any earlier edge. While no frame-clock edge arrives, `conv_ready` stays 0.
- R4: With `mode_fall` = 0 only rising frame-clock edges qualify. With `mode_fall` = 1 only falling edges qualify. `mode_fall` may change only while `pwr_dn_n` is low.
- R5: Once `conv_ready` is 1, it stays 1 through any number of further frames until `pwr_dn_n` goes low. The counter saturates and does not wrap.
- R6: While `conv_ready` is 1, `m_left` equals `s_left` and `m_right` equals `s_right`.
- R7: `m_valid` always equals `s_valid` and `s_ready` always equals `m_ready`, so the stream holds no storage.
- R8: Taking `pwr_dn_n` low in the middle of initialization discards the progress. The next release needs the full count again.
- R9: `filt_rst` falls on the second master-clock rising edge after `pwr_dn_n` rises, because of the two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| pwr_dn_n | input | 1 | Power-down, active low, asynchronous |
| frame_clk | input | 1 | Frame (left/right) clock, asynchronous to clk |
| mode_fall | input | 1 | 1: falling frame edges qualify; 0: rising edges |
| s_valid | input | 1 | Input sample pair valid |
| s_ready | output | 1 | Input sample pair accepted (equals m_ready) |
| s_left | input | W | Left channel sample word |
| s_right | input | W | Right channel sample word |
| m_valid | output | 1 | Output sample pair valid |
| m_ready | input | 1 | Downstream ready for output pair |
| m_left | output | W | Gated left word |
| m_right | output | W | Gated right word |
| conv_ready | output | 1 | Initialization complete, data passing |
| filt_rst | output | 1 | Decimation filter reset, active high |

## Verification
The assertions assume three things about the inputs. `mode_fall` is constant outside power-down. The frame clock is much slower than the master clock, so each level lasts several master-clock cycles and the synchronizer sees every edge. Every input changes away from the rising edge of `clk`. The stimulus changes every input on the falling edge of `clk`, holds each frame-clock level for four master cycles, and changes the mode only while power-down is held low. Under those conditions, the edge-polarity check can trace the rise of `conv_ready` back through the synchronizer delay to a clean frame-clock transition.

// File: rtl/adc_init_seq_pkg.sv
package adc_init_seq_pkg;
  typedef enum logic [1:0] {
    PH_ARM   = 2'd0,
    PH_COUNT = 2'd1,
    PH_LIVE  = 2'd2
  } init_phase_t;
endpackage

// File: rtl/isq_pd_sync.sv
module isq_pd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic pd_n,
  output logic run
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge pd_n) begin
    if (!pd_n) chain <= '0;
    else       chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign run = chain[STAGES-1];
endmodule

// File: rtl/isq_edge_pick.sv
module isq_edge_pick #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic frame_clk,
  input  logic fall_mode,
  output logic hit
);
  localparam int DEPTH = STAGES + 1;
  logic [DEPTH-1:0] tap;

  always_ff @(posedge clk) begin
    tap <= {tap[DEPTH-2:0], frame_clk};
  end

  logic now_lvl, old_lvl;
  assign now_lvl = tap[DEPTH-2];
  assign old_lvl = tap[DEPTH-1];
  assign hit = fall_mode ? (old_lvl & ~now_lvl) : (now_lvl & ~old_lvl);
endmodule

// File: rtl/isq_frame_timer.sv
module isq_frame_timer
  import adc_init_seq_pkg::*;
#(
  parameter int INIT_FRAMES = 4129
) (
  input  logic clk,
  input  logic run,
  input  logic hit,
  output logic live
);
  localparam int CNT_W = $clog2(INIT_FRAMES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INIT_FRAMES - 1);
  localparam logic [CNT_W-1:0] TERM = CNT_W'(INIT_FRAMES);

  init_phase_t      phase;
  logic [CNT_W-1:0] frames;

  always_ff @(posedge clk or negedge run) begin
    if (!run) begin
      phase  <= PH_ARM;
      frames <= '0;
    end else begin
      unique case (phase)
        PH_ARM: if (hit) begin
          phase  <= PH_COUNT;
          frames <= '0;
        end
        PH_COUNT: if (hit) begin
          if (frames == LAST) begin
            phase  <= PH_LIVE;
            frames <= TERM;
          end else begin
            frames <= frames + 1'b1;
          end
        end
        PH_LIVE: frames <= TERM;
        default: phase <= PH_ARM;
      endcase
    end
  end

  assign live = (phase == PH_LIVE);
endmodule

// File: rtl/isq_out_gate.sv
module isq_out_gate #(
  parameter int W  = 24,
  parameter int NCH = 2
) (
  input  logic                open,
  input  logic [NCH-1:0][W-1:0] din,
  output logic [NCH-1:0][W-1:0] dout
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign dout[c] = open ? din[c] : '0;
  end
endmodule

// File: rtl/adc_init_seq.sv
module adc_init_seq #(
  parameter int W           = 24,
  parameter int INIT_FRAMES = 4129,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         pwr_dn_n,
  input  logic         frame_clk,
  input  logic         mode_fall,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_left,
  input  logic [W-1:0] s_right,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_left,
  output logic [W-1:0] m_right,
  output logic         conv_ready,
  output logic         filt_rst
);
  localparam int NCH = 2;

  logic run, hit, live;
  logic [NCH-1:0][W-1:0] words_in, words_out;

  isq_pd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .pd_n(pwr_dn_n), .run(run)
  );

  isq_edge_pick #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .frame_clk(frame_clk), .fall_mode(mode_fall), .hit(hit)
  );

  isq_frame_timer #(.INIT_FRAMES(INIT_FRAMES)) u_timer (
    .clk(clk), .run(run), .hit(hit), .live(live)
  );

  assign words_in[0] = s_left;
  assign words_in[1] = s_right;

  isq_out_gate #(.W(W), .NCH(NCH)) u_gate (
    .open(live), .din(words_in), .dout(words_out)
  );

  assign m_left     = words_out[0];
  assign m_right    = words_out[1];
  assign m_valid    = s_valid;
  assign s_ready    = m_ready;
  assign conv_ready = live;
  assign filt_rst   = ~run;
endmodule

// File: rtl/adc_init_seq_chk.sv
module adc_init_seq_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         pwr_dn_n,
  input logic         frame_clk,
  input logic         mode_fall,
  input logic [W-1:0] s_left,
  input logic [W-1:0] s_right,
  input logic [W-1:0] m_left,
  input logic [W-1:0] m_right,
  input logic         conv_ready,
  input logic         filt_rst
);
  // R1: power-down holds the filter in reset and keeps the flag low
  a_r1_pd_holds: assert property (@(posedge clk)
    !pwr_dn_n |-> (filt_rst && !conv_ready));

  // R2: outputs are zero until ready
  a_r2_zero_gate: assert property (@(posedge clk) disable iff (!pwr_dn_n)
    !conv_ready |-> (m_left == '0 && m_right == '0));

  // R6: outputs follow inputs once ready
  a_r6_pass: assert property (@(posedge clk) disable iff (!pwr_dn_n)
    conv_ready |-> (m_left == s_left && m_right == s_right));

  // R5: the ready flag is sticky until power-down
  a_r5_sticky: assert property (@(posedge clk) disable iff (!pwr_dn_n)
    conv_ready |=> conv_ready);

  // R3: filter reset is released before ready can be high
  a_r3_rst_before_ready: assert property (@(posedge clk) disable iff (!pwr_dn_n)
    conv_ready |-> !filt_rst);

  // R4: the ready rise traces back to a frame edge of the selected polarity
  a_r4_edge_polarity: assert property (@(posedge clk) disable iff (!pwr_dn_n)
    $rose(conv_ready) |->
      (mode_fall ? (!$past(frame_clk, 3) && $past(frame_clk, 4))
                 : ($past(frame_clk, 3) && !$past(frame_clk, 4))));
endmodule

bind adc_init_seq adc_init_seq_chk #(.W(W)) u_chk (
  .clk(clk), .pwr_dn_n(pwr_dn_n), .frame_clk(frame_clk), .mode_fall(mode_fall),
  .s_left(s_left), .s_right(s_right), .m_left(m_left), .m_right(m_right),
  .conv_ready(conv_ready), .filt_rst(filt_rst)
);

// File: tb/adc_init_seq_tb.sv
module adc_init_seq_tb;
  localparam int W     = 24;
  localparam int INIT  = 4129;
  localparam int HALF  = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         pwr_dn_n, frame_clk, mode_fall, s_valid, m_ready;
  logic [W-1:0] s_left, s_right;
  logic         s_ready, m_valid, conv_ready, filt_rst;
  logic [W-1:0] m_left, m_right;

  adc_init_seq #(.W(W), .INIT_FRAMES(INIT)) u_dut (
    .clk(clk), .pwr_dn_n(pwr_dn_n), .frame_clk(frame_clk), .mode_fall(mode_fall),
    .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
    .m_valid(m_valid), .m_ready(m_ready), .m_left(m_left), .m_right(m_right),
    .conv_ready(conv_ready), .filt_rst(filt_rst)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [W-1:0] l;
    logic [W-1:0] r;
    logic         v;
    logic         rdy;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{24'h000001, 24'hFFFFFF, 1'b1, 1'b1},
    '{24'h7FFFFF, 24'h800000, 1'b1, 1'b0},
    '{24'h123456, 24'h654321, 1'b0, 1'b1},
    '{24'hA5A5A5, 24'h5A5A5A, 1'b1, 1'b1},
    '{24'h800000, 24'h7FFFFF, 1'b0, 1'b0},
    '{24'h00FF00, 24'hFF00FF, 1'b1, 1'b0},
    '{24'hFFFFFE, 24'h000002, 1'b1, 1'b1},
    '{24'h3C3C3C, 24'hC3C3C3, 1'b0, 1'b1}
  };

  task automatic walk(input bit open, input string tag);
    for (int i = 0; i < 8; i++) begin
      s_left = VECS[i].l; s_right = VECS[i].r;
      s_valid = VECS[i].v; m_ready = VECS[i].rdy;
      @(negedge clk); #1;
      chk(m_left == (open ? VECS[i].l : '0), {tag, " left"}, m_left, open ? VECS[i].l : '0);
      chk(m_right == (open ? VECS[i].r : '0), {tag, " right"}, m_right, open ? VECS[i].r : '0);
      chk(m_valid == VECS[i].v && s_ready == VECS[i].rdy, "R7 handshake",
          {m_valid, s_ready}, {VECS[i].v, VECS[i].rdy});
    end
  endtask

  task automatic toggles(input int n);
    for (int i = 0; i < n; i++) begin
      frame_clk = ~frame_clk;
      repeat (HALF) @(negedge clk);
    end
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    pwr_dn_n = 1'b0; frame_clk = 1'b0; mode_fall = 1'b0;
    s_valid = 1'b1; m_ready = 1'b1; s_left = 24'h111111; s_right = 24'h222222;
    repeat (6) @(negedge clk);
    // R1: reset state
    chk(filt_rst && !conv_ready, "R1 pd state", {filt_rst, conv_ready}, 2'b10);
    chk(m_left == 0 && m_right == 0, "R1 zero out", {m_left, m_right}, 0);

    // R9: synchronizer latency
    pwr_dn_n = 1'b1;
    @(negedge clk);
    chk(filt_rst == 1'b1, "R9 still reset after 1 edge", filt_rst, 1);
    @(negedge clk);
    chk(filt_rst == 1'b0, "R9 released after 2 edges", filt_rst, 0);

    // R3: no frame edges -> never ready
    repeat (40) @(negedge clk);
    chk(conv_ready == 1'b0, "R3 no edges", conv_ready, 0);
    walk(1'b0, "R2 init gate");

    // R3: exact count, rising mode
    toggles(2 * INIT);
    chk(conv_ready == 1'b0, "R3 one edge short", conv_ready, 0);
    toggles(1);
    chk(conv_ready == 1'b1, "R3 ready on final edge", conv_ready, 1);
    walk(1'b1, "R6 pass");

    // R5: sticky and saturating
    toggles(40);
    chk(conv_ready == 1'b1, "R5 sticky", conv_ready, 1);

    // R1: asynchronous effect of power-down
    @(negedge clk); #1;
    pwr_dn_n = 1'b0; #1;
    chk(!conv_ready && filt_rst, "R1 async clear", {conv_ready, filt_rst}, 2'b01);
    chk(m_left == 0 && m_right == 0, "R1 async zero", {m_left, m_right}, 0);

    // R4: falling-edge mode, frame clock starts high
    @(negedge clk);
    mode_fall = 1'b1; frame_clk = 1'b1;
    repeat (4) @(negedge clk);
    pwr_dn_n = 1'b1;
    repeat (4) @(negedge clk);
    toggles(2 * INIT);
    chk(conv_ready == 1'b0, "R4 fall mode short", conv_ready, 0);
    toggles(1);
    chk(conv_ready == 1'b1, "R4 fall mode ready", conv_ready, 1);

    // R8: abort mid-init, full recount afterwards
    pwr_dn_n = 1'b0;
    @(negedge clk);
    mode_fall = 1'b0; frame_clk = 1'b0;
    repeat (4) @(negedge clk);
    pwr_dn_n = 1'b1;
    repeat (4) @(negedge clk);
    toggles(200);
    pwr_dn_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(conv_ready == 1'b0 && filt_rst, "R8 abort clears", {conv_ready, filt_rst}, 2'b01);
    pwr_dn_n = 1'b1;
    repeat (4) @(negedge clk);
    toggles(2 * INIT);
    chk(conv_ready == 1'b0, "R8 full recount short", conv_ready, 0);
    toggles(1);
    chk(conv_ready == 1'b1, "R8 full recount ready", conv_ready, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule